// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This unit sits beside a processor's integer pipeline and keeps a 64-bit accumulator as two 32-bit halves, HI (upper word) and LO (lower word). It takes two 32-bit operands and a 3-bit operation code with a valid strobe. It can add a product into the accumulator, subtract a product from it, or run a plain multiply whose low 32 bits go to a result port for a general register. Each accumulate form comes in a signed and an unsigned variant. Arithmetic always wraps and never raises a flag.

The multiplier is iterative. It handles `STEP` bits of the second operand per clock, so one operation takes `W/STEP` busy cycles, which is 4 with the defaults. While it works it raises `busy`. When it finishes it raises `done` for one cycle. Software-side logic can load HI and LO through write ports while the unit is idle, and can read them at any time.

Top module: `hilo_mac`

## Requirements
- R1: After reset, HI, LO and `rd_result` read zero, and `busy` and `done` are low.
- R2: An operation is accepted on a clock edge where `op_valid` is high, `busy` is low and `op_code` is 0 to 4. `busy` is then high for exactly W/STEP cycles (4 by default).
- R3: `done` is high for exactly one cycle per accepted operation. That cycle directly follows the last busy cycle, and `busy` is low during it.
- R4: Code 0 treats both operands as signed two's complement. It replaces {HI,LO} with {HI,LO} plus the 64-bit product.
- R5: Code 1 treats both operands as unsigned. It replaces {HI,LO} with {HI,LO} plus the 64-bit product.
- R6: Code 2 treats both operands as signed. It replaces {HI,LO} with {HI,LO} minus the 64-bit product.
- R7: Code 3 treats both operands as unsigned. It replaces {HI,LO} with {HI,LO} minus the 64-bit product.
- R8: Accumulation wraps modulo 2^64. A carry or borrow out of bit 63 is dropped, and no error indication exists.
- R9: Code 4 multiplies the operands as signed values. It places the low 32 bits of the product on `rd_result`. `rd_result` changes only at the completion of a code-4 operation. The values of HI and LO after code 4 are unspecified.
- R10: Codes 5, 6 and 7 are not accepted. `busy` and `done` stay low, and HI and LO keep their values.
- R11: `op_valid` is ignored while `busy` is high. A request held through an operation yields no extra `done`.
- R12: When `busy` is low, `hi_we`/`lo_we` load `hi_wdata`/`lo_wdata`, and the new value reads back from the next cycle. While `busy` is high, these writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request strobe |
| op_code | input | 3 | 0 signed add, 1 unsigned add, 2 signed subtract, 3 unsigned subtract, 4 multiply |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_result | output | 32 | Low word of the last plain multiply |
| hi_we | input | 1 | Load HI |
| hi_wdata | input | 32 | Value for HI |
| lo_we | input | 1 | Load LO |
| lo_wdata | input | 32 | Value for LO |
| hi_rdata | output | 32 | Current HI |
| lo_rdata | output | 32 | Current LO |

## Verification
The assertions assume that the stimulus stays synchronous to `clk` and leaves no input unknown after reset. This lets the properties for a request while idle and for accumulator stability during `busy` apply on every edge. The bench drives all inputs on the falling edge, so each sampled value is settled and defined.

The stimulus deliberately violates the handshake in two ways: it holds `op_valid` through a running operation, and it writes HI and LO while `busy` is high. Both cases fall within the behaviour the properties describe, so they exercise the ignore paths without breaking an assumption.

// File: rtl/hilo_mac.sv
module hilo_mac #(
  parameter int W    = 32,
  parameter int STEP = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rd_result,
  input  logic         hi_we,
  input  logic [W-1:0] hi_wdata,
  input  logic         lo_we,
  input  logic [W-1:0] lo_wdata,
  output logic [W-1:0] hi_rdata,
  output logic [W-1:0] lo_rdata
);
  localparam int NSTEP = W / STEP;
  localparam int CW    = $clog2(NSTEP + 1);
  localparam int AW    = 2 * W;
  localparam logic [2:0] OP_MAC  = 3'd0;
  localparam logic [2:0] OP_MACU = 3'd1;
  localparam logic [2:0] OP_MSB  = 3'd2;
  localparam logic [2:0] OP_MSBU = 3'd3;
  localparam logic [2:0] OP_MUL  = 3'd4;

  logic [W-1:0]  hi_q, lo_q, rd_q, mplier_q;
  logic [AW-1:0] mcand_q, prod_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    op_q;
  logic          busy_q, done_q, neg_q;

  logic          accept, is_signed, a_neg, b_neg, is_sub;
  logic [W-1:0]  a_mag, b_mag;
  logic [AW-1:0] prod_nxt, prod_fin, acc_nxt;

  assign accept    = op_valid && !busy_q && (op_code <= OP_MUL);
  assign is_signed = (op_code == OP_MAC) || (op_code == OP_MSB) || (op_code == OP_MUL);
  assign a_neg     = is_signed && op_a[W-1];
  assign b_neg     = is_signed && op_b[W-1];
  assign a_mag     = a_neg ? -op_a : op_a;
  assign b_mag     = b_neg ? -op_b : op_b;

  assign prod_nxt  = prod_q + mcand_q * {{(AW-STEP){1'b0}}, mplier_q[STEP-1:0]};
  assign prod_fin  = neg_q ? -prod_nxt : prod_nxt;
  assign is_sub    = (op_q == OP_MSB) || (op_q == OP_MSBU);
  assign acc_nxt   = is_sub ? ({hi_q, lo_q} - prod_fin) : ({hi_q, lo_q} + prod_fin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      lo_q     <= '0;
      rd_q     <= '0;
      mplier_q <= '0;
      mcand_q  <= '0;
      prod_q   <= '0;
      cnt_q    <= '0;
      op_q     <= OP_MAC;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      neg_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        op_q     <= op_code;
        neg_q    <= a_neg ^ b_neg;
        mcand_q  <= {{W{1'b0}}, a_mag};
        mplier_q <= b_mag;
        prod_q   <= '0;
        cnt_q    <= CW'(NSTEP);
        busy_q   <= 1'b1;
      end
      if (busy_q) begin
        prod_q   <= prod_nxt;
        mcand_q  <= mcand_q << STEP;
        mplier_q <= mplier_q >> STEP;
        cnt_q    <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (op_q == OP_MUL) rd_q <= prod_fin[W-1:0];
          else {hi_q, lo_q} <= acc_nxt;
        end
      end else begin
        if (hi_we) hi_q <= hi_wdata;
        if (lo_we) lo_q <= lo_wdata;
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign rd_result = rd_q;
  assign hi_rdata  = hi_q;
  assign lo_rdata  = lo_q;
endmodule

// File: rtl/hilo_mac_chk.sv
module hilo_mac_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [2:0]   op_code,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] rd_result,
  input logic [W-1:0] hi_rdata,
  input logic [W-1:0] lo_rdata
);
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && op_code <= 3'd4) |=> busy);
  assert_bad_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && op_code > 3'd4) |=> (!busy && !done));
  assert_hold_acc_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done || ($stable(hi_rdata) && $stable(lo_rdata))));
  assert_rd_only_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_result) |-> done);
endmodule

bind hilo_mac hilo_mac_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .busy(busy), .done(done), .rd_result(rd_result),
  .hi_rdata(hi_rdata), .lo_rdata(lo_rdata)
);

// File: tb/hilo_mac_tb_top.sv
module hilo_mac_tb_top;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, hi_we = 1'b0, lo_we = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [31:0] op_a = '0, op_b = '0, hi_wdata = '0, lo_wdata = '0;
  logic busy, done;
  logic [31:0] rd_result, hi_rdata, lo_rdata;
  int nrun = 0, nfail = 0, ndone = 0, cycles = 0;

  always #10 clk = ~clk;

  hilo_mac dut_i (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .rd_result(rd_result),
    .hi_we(hi_we), .hi_wdata(hi_wdata), .lo_we(lo_we), .lo_wdata(lo_wdata),
    .hi_rdata(hi_rdata), .lo_rdata(lo_rdata));

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    nrun++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // behavioural reference
  logic [63:0] m_acc;
  logic [31:0] m_rd, p_a, p_b;
  logic [2:0]  p_code;
  logic m_busy, m_done, m_hi_ok, m_lo_ok, seen_edge = 1'b0;
  int m_cnt;
  string m_tag = "R1";

  function automatic logic [63:0] ref_prod(logic [2:0] c, logic [31:0] a, logic [31:0] b);
    if (c == 3'd1 || c == 3'd3) return {32'b0, a} * {32'b0, b};
    return 64'(longint'($signed(a)) * longint'($signed(b)));
  endfunction

  always @(posedge clk) begin
    seen_edge <= 1'b1;
    if (!rst_n) begin
      m_acc = '0; m_rd = '0; m_busy = 0; m_done = 0; m_cnt = 0;
      m_hi_ok = 1; m_lo_ok = 1; m_tag = "R1";
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          case (p_code)
            3'd0: begin m_acc = m_acc + ref_prod(p_code, p_a, p_b); m_tag = "R4"; end
            3'd1: begin m_acc = m_acc + ref_prod(p_code, p_a, p_b); m_tag = "R5"; end
            3'd2: begin m_acc = m_acc - ref_prod(p_code, p_a, p_b); m_tag = "R6"; end
            3'd3: begin m_acc = m_acc - ref_prod(p_code, p_a, p_b); m_tag = "R7"; end
            default: begin m_rd = ref_prod(p_code, p_a, p_b) >> 0; m_hi_ok = 0; m_lo_ok = 0; end
          endcase
        end
      end else begin
        if (hi_we) begin m_acc[63:32] = hi_wdata; m_hi_ok = 1; m_tag = "R12"; end
        if (lo_we) begin m_acc[31:0] = lo_wdata; m_lo_ok = 1; m_tag = "R12"; end
        if (op_valid && op_code <= 3'd4) begin
          m_busy = 1; m_cnt = N; p_code = op_code; p_a = op_a; p_b = op_b;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && seen_edge) begin
      check("R2 busy", 64'(busy), 64'(m_busy));
      check("R3 done", 64'(done), 64'(m_done));
      check("R9 rd_result", 64'(rd_result), 64'(m_rd));
      if (m_hi_ok) check({m_tag, " HI"}, 64'(hi_rdata), 64'(m_acc[63:32]));
      if (m_lo_ok) check({m_tag, " LO"}, 64'(lo_rdata), 64'(m_acc[31:0]));
      if (done) ndone++;
    end
    if (cycles > 150000) begin
      nfail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end

  task automatic wr(logic [31:0] h, logic [31:0] l);
    @(negedge clk); hi_we = 1; lo_we = 1; hi_wdata = h; lo_wdata = l;
    @(negedge clk); hi_we = 0; lo_we = 0;
  endtask

  task automatic issue(logic [2:0] c, logic [31:0] a, logic [31:0] b);
    @(negedge clk); op_valid = 1; op_code = c; op_a = a; op_b = b;
    @(negedge clk); op_valid = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 HI", 64'(hi_rdata), 0);
    check("R1 LO", 64'(lo_rdata), 0);
    check("R1 busy/done", {62'b0, busy, done}, 0);

    wr(32'h0, 32'h5);
    issue(3'd0, -32'sd3, 32'd7);
    check("R4 signed add", {hi_rdata, lo_rdata}, 64'hFFFF_FFFF_FFFF_FFF0);

    wr(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    issue(3'd1, 32'd1, 32'd1);
    check("R8 wrap add", {hi_rdata, lo_rdata}, 64'h0);

    issue(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R5 unsigned add", {hi_rdata, lo_rdata}, 64'hFFFF_FFFE_0000_0001);

    wr(32'h0, 32'h0);
    issue(3'd3, 32'd2, 32'd3);
    check("R7 R8 borrow", {hi_rdata, lo_rdata}, 64'hFFFF_FFFF_FFFF_FFFA);

    wr(32'h0, 32'h0);
    issue(3'd2, 32'h8000_0000, 32'h8000_0000);
    check("R6 signed sub", {hi_rdata, lo_rdata}, 64'hC000_0000_0000_0000);

    issue(3'd4, 32'h8000_0000, 32'hFFFF_FFFF);
    check("R9 mul low word", 64'(rd_result), 64'h8000_0000);
    issue(3'd4, -32'sd7, 32'd6);
    check("R9 mul negative", 64'(rd_result), 64'(-32'sd42 & 32'hFFFF_FFFF));

    wr(32'h1234_5678, 32'h9ABC_DEF0);
    d0 = ndone;
    @(negedge clk); op_valid = 1; op_code = 3'd6; op_a = 5; op_b = 5;
    @(negedge clk); op_valid = 0;
    check("R10 no busy", 64'(busy), 0);
    repeat (3) @(negedge clk);
    check("R10 no done", 64'(ndone - d0), 0);
    check("R10 acc kept", {hi_rdata, lo_rdata}, 64'h1234_5678_9ABC_DEF0);

    d0 = ndone;
    @(negedge clk); op_valid = 1; op_code = 3'd0; op_a = 2; op_b = 3;
    @(negedge clk); op_code = 3'd1; op_a = 100; op_b = 100;
    hi_we = 1; lo_we = 1; hi_wdata = 32'hDEAD; lo_wdata = 32'hBEEF;
    repeat (2) @(negedge clk);
    op_valid = 0; hi_we = 0; lo_we = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R11 single done", 64'(ndone - d0), 1);
    check("R12 busy write ignored", {hi_rdata, lo_rdata}, 64'h1234_5678_9ABC_DEF6);

    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 3) == 0) wr($urandom, $urandom);
      issue(3'($urandom_range(0, 5)), $urandom, $urandom);
    end

    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule